// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master that hangs off a simple byte-wide register bus. Software sees a control register, a baud register, a status register and a data port. A write to the data port lands in a one-byte transmit holding buffer. The byte moves into the shift register as soon as the shifter is free, so software can queue the next byte while the current one is still going out. Two bytes written in time leave the block as one unbroken 16-clock burst. The received byte is copied into a read-only receive register when the frame ends.

Only master operation in clock mode 0 is provided: the serial clock idles low, input data is captured on rising edges and output data changes on falling edges, with 8 bits per frame sent most significant bit first. The serial clock period is the bus clock period multiplied by a prescale factor and a power-of-two divisor. Flags clear only through a status-then-data access pair. If a new byte completes while the previous one is still unread, an overrun flag is raised. There is no slave-select output: software frames multi-byte commands with a general-purpose pin. The `busy` output tells it when the last frame has ended.

Register offsets on `bus_addr` are: 0 control, 1 baud, 2 status (read), 3 data (write to the transmit buffer, read from the receive register).

Top module: `spi_dbuf_master`

## Requirements
- R1: A synchronous active-high reset makes status (offset 2) read 0x20, with bit 5 tx-empty = 1, bit 7 rx-full = 0 and bit 6 overrun = 0. It also drives `sclk`, `mosi` and `busy` low.
- R2: Each frame is 8 bits in mode 0, most significant bit first. `mosi` changes only on falling `sclk` edges, and `miso` is captured on rising edges. The byte captured is returned by a data read at offset 3.
- R3: Baud register (offset 1) bits [6:4] hold P and bits [2:0] hold D. The serial clock period is (P+1)*2^(D+1) bus cycles, so D=0 divides by 2 and D=1 divides by 4.
- R4: Tx-empty sets in the cycle the buffered byte moves into the shift register. A byte buffered before the current frame ends is loaded at that frame's last falling edge, so rising edges stay exactly one period apart across the byte boundary.
- R5: A data write (offset 3) is accepted only if tx-empty was set and a status read has seen tx-empty set since the last accepted write. Acceptance clears tx-empty. Any other data write is ignored.
- R6: Rx-full sets when a frame completes. It clears only on a status read that sees it set followed by a data read. A data read without that status read leaves it set.
- R7: When a frame completes while rx-full is still set, overrun (status bit 6) sets and the receive register takes the newer byte. The clearing sequence of R6 also clears overrun.
- R8: `busy` is high from the load of a byte into the shift register until the falling edge that ends the last queued frame. Whenever `busy` is low, `sclk` and `mosi` are low.
- R9: While control bit 0 (offset 0, enable) is 0, no byte leaves the transmit buffer and no serial clock is produced. Setting it starts any queued byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for flag sequencing) |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Shift register holds an unsent or partly sent byte |

## Verification
The bound checker watches, on every cycle, the properties that are local in time. The serial clock toggles only on a half-period tick and stays low with `mosi` when idle. Tx-empty falls only after a data write and rises only when a byte is taken. Rx-full and overrun rise only at a frame completion. The exact clock period for each prescale and divisor setting, the absence of a gap between two queued bytes, the bit order on both data lines, the overrun case in which the first byte is lost, and the ignoring of unarmed writes and unarmed reads depend on whole access sequences. Only the bench scenarios, with their loopback slave model and expected-byte queue, can show them.

// File: rtl/spi_dbm_pkg.sv
package spi_dbm_pkg;
  localparam int PRE_W = 3;
  localparam int DIV_W = 3;

  typedef struct packed {
    logic       rx_full;
    logic       overrun;
    logic       tx_empty;
    logic [4:0] zero;
  } spi_status_t;

  // half of one serial clock period, in bus cycles
  function automatic int unsigned half_cycles(input logic [PRE_W-1:0] pre,
                                              input logic [DIV_W-1:0] div);
    return (32'(pre) + 32'd1) << div;
  endfunction
endpackage

// File: rtl/spi_dbm_clkdiv.sv
module spi_dbm_clkdiv #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt >= half - CNT_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (at_end)  cnt <= '0;
    else              cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/spi_dbm_shifter.sv
module spi_dbm_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load_req,
  input  logic [DW-1:0] load_data,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          active,
  output logic          take,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int BW = $clog2(DW);

  logic [DW-1:0] tx_sh;
  logic [DW-1:0] rx_sh;
  logic [BW-1:0] bit_cnt;
  logic          last;

  assign last    = (bit_cnt == BW'(DW - 1));
  assign done    = active && tick && sclk && last;
  assign take    = (!active && load_req) || (done && load_req);
  assign mosi    = active && tx_sh[DW-1];
  assign rx_byte = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_cnt <= '0;
    end else if (!active) begin
      if (load_req) begin
        active  <= 1'b1;
        tx_sh   <= load_data;
        bit_cnt <= '0;
        sclk    <= 1'b0;
      end
    end else if (tick) begin
      if (!sclk) begin
        sclk  <= 1'b1;
        rx_sh <= {rx_sh[DW-2:0], miso};
      end else begin
        sclk <= 1'b0;
        if (last) begin
          if (load_req) begin
            tx_sh   <= load_data;
            bit_cnt <= '0;
          end else begin
            active <= 1'b0;
          end
        end else begin
          tx_sh   <= {tx_sh[DW-2:0], 1'b0};
          bit_cnt <= bit_cnt + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi_dbm_flags.sv
module spi_dbm_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_full,
  output logic [DW-1:0] tx_buf,
  output logic          rx_full,
  output logic          overrun,
  output logic [DW-1:0] rx_data,
  output logic          wr_accept,
  output logic          rd_release
);
  logic arm_tx;
  logic arm_rx;

  assign wr_accept  = data_wr && arm_tx && !tx_full;
  assign rd_release = data_rd && arm_rx && rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
      arm_tx  <= 1'b0;
    end else begin
      if (wr_accept) begin
        tx_full <= 1'b1;
        tx_buf  <= wdata;
        arm_tx  <= 1'b0;
      end else begin
        if (take)                 tx_full <= 1'b0;
        if (stat_rd && !tx_full)  arm_tx  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full <= 1'b0;
      overrun <= 1'b0;
      rx_data <= '0;
      arm_rx  <= 1'b0;
    end else begin
      if (done) begin
        rx_data <= rx_byte;
        rx_full <= 1'b1;
        if (rx_full && !rd_release) overrun <= 1'b1;
        else if (rd_release)        overrun <= 1'b0;
      end else if (rd_release) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
      if (rd_release)               arm_rx <= 1'b0;
      else if (stat_rd && rx_full)  arm_rx <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          busy
);
  localparam int CNT_W = PRE_W + (1 << DIV_W);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_BAUD = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  logic [DW-1:0]    ctrl_q;
  logic [DW-1:0]    baud_q;
  logic [CNT_W-1:0] half;
  logic             half_tick;
  logic             buf_take;
  logic             byte_done;
  logic             active;
  logic [DW-1:0]    rx_byte;
  logic             tx_full;
  logic [DW-1:0]    tx_buf;
  logic             rx_full;
  logic             ovr_flag;
  logic [DW-1:0]    rx_data;
  logic             wr_accept;
  logic             rd_release;
  logic             tx_empty;
  logic             stat_rd;
  logic             data_rd;
  logic             data_wr;
  spi_status_t      status;

  assign stat_rd  = bus_rd && (bus_addr == A_STAT);
  assign data_rd  = bus_rd && (bus_addr == A_DATA);
  assign data_wr  = bus_wr && (bus_addr == A_DATA);
  assign tx_empty = !tx_full;
  assign busy     = active;
  assign half     = CNT_W'(half_cycles(baud_q[4 +: PRE_W], baud_q[0 +: DIV_W]));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      baud_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata;
      if (bus_addr == A_BAUD) baud_q <= bus_wdata;
    end
  end

  always_comb begin
    status = '{rx_full: rx_full, overrun: ovr_flag, tx_empty: tx_empty, zero: 5'd0};
    unique case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_BAUD:  bus_rdata = baud_q;
      A_STAT:  bus_rdata = DW'(status);
      default: bus_rdata = rx_data;
    endcase
  end

  spi_dbm_clkdiv #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .run(active), .half(half), .tick(half_tick)
  );

  spi_dbm_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .tick(half_tick),
    .load_req(tx_full && ctrl_q[0]), .load_data(tx_buf), .miso(miso),
    .sclk(sclk), .mosi(mosi), .active(active), .take(buf_take),
    .done(byte_done), .rx_byte(rx_byte)
  );

  spi_dbm_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .wdata(bus_wdata), .take(buf_take), .done(byte_done),
    .rx_byte(rx_byte), .tx_full(tx_full), .tx_buf(tx_buf), .rx_full(rx_full),
    .overrun(ovr_flag), .rx_data(rx_data), .wr_accept(wr_accept),
    .rd_release(rd_release)
  );
endmodule

// File: rtl/spi_dbm_chk.sv
module spi_dbm_chk (
  input logic       clk,
  input logic       rst,
  input logic       sclk,
  input logic       mosi,
  input logic       busy,
  input logic       half_tick,
  input logic       take,
  input logic       done,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       ovr,
  input logic       bus_wr,
  input logic [1:0] bus_addr
);
  // R8
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !sclk);
  // R8
  mosi_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mosi);
  // R3
  sclk_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> $past(half_tick));
  // R5
  txe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_empty) |-> $past(bus_wr && bus_addr == 2'd3));
  // R4
  txe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_empty) |-> $past(take));
  // R6
  rxf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(done));
  // R7
  ovr_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(done) && rx_full);
endmodule

bind spi_dbuf_master spi_dbm_chk u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .mosi(mosi), .busy(busy),
  .half_tick(half_tick), .take(buf_take), .done(byte_done),
  .tx_empty(tx_empty), .rx_full(rx_full), .ovr(ovr_flag),
  .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/spi_dbuf_master_tb.sv
module spi_dbuf_master_tb;
  localparam int CLK_PER = 10;

  logic       clk = 0;
  logic       rst = 1;
  logic       bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       sclk, mosi, miso, busy;

  int total = 0, bad = 0;
  int cyc = 0;
  int n_edge = 0;
  int edge_cyc[32];

  logic       ss_n = 1;
  logic [7:0] sl_sh = 0, sl_rx = 0;
  int         sl_bits = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rep_q[$];

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc++;

  spi_dbuf_master u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .busy(busy)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // loopback slave model with scoreboard monitor
  assign miso = sl_sh[7];
  always @(negedge ss_n) begin
    sl_bits = 0;
    sl_sh = (rep_q.size() > 0) ? rep_q.pop_front() : 8'h00;
  end
  always @(posedge sclk) begin
    if (n_edge < 32) edge_cyc[n_edge] = cyc;
    n_edge++;
    if (!ss_n) begin
      sl_rx = {sl_rx[6:0], mosi};
      sl_bits++;
      if (sl_bits == 8) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected byte on mosi", sl_rx, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(sl_rx == e, "R2 mosi byte", sl_rx, e);
        end
      end
    end
  end
  always @(negedge sclk) begin
    if (!ss_n) begin
      if (sl_bits == 8) begin
        sl_bits = 0;
        sl_sh = (rep_q.size() > 0) ? rep_q.pop_front() : 8'h00;
      end else sl_sh = {sl_sh[6:0], 1'b0};
    end
  end

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask
  task automatic wait_txe();
    logic [7:0] s;
    do rd(2'd2, s); while (!s[5]);
  endtask
  task automatic wait_idle();
    repeat (3) @(posedge clk);
    while (busy) @(posedge clk);
    @(negedge clk);
  endtask
  // driver: queue expected mosi byte and slave reply
  task automatic queue_byte(input logic [7:0] tx, input logic [7:0] rep);
    exp_q.push_back(tx);
    rep_q.push_back(rep);
  endtask
  task automatic edges_ok(input int n, input int per, input string tag);
    logic ok;
    ok = (n_edge == n);
    for (int i = 1; i < n && i < 32; i++)
      if (edge_cyc[i] - edge_cyc[i-1] != per) ok = 0;
    chk(ok, tag, (n_edge > 1) ? edge_cyc[1] - edge_cyc[0] : n_edge, per);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    int pv[4] = '{0, 7, 7, 2};
    int dv[4] = '{0, 0, 1, 2};
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!sclk && !mosi && !busy, "R1 pins after reset", {sclk, mosi, busy}, 0);
    rd(2'd2, s);
    chk(s == 8'h20, "R1 status after reset", s, 8'h20);
    wr(2'd0, 8'h01);

    // R3 period per setting, R2 data both ways
    for (int k = 0; k < 4; k++) begin
      logic [7:0] tx, rp;
      int per;
      tx = 8'h96 ^ 8'(k * 37);
      rp = 8'h5B + 8'(k * 29);
      per = (pv[k] + 1) * (2 ** (dv[k] + 1));
      wr(2'd1, 8'((pv[k] << 4) | dv[k]));
      queue_byte(tx, rp);
      n_edge = 0;
      ss_n = 0;
      wait_txe();
      wr(2'd3, tx);
      wait_idle();
      ss_n = 1;
      edges_ok(8, per, "R3 serial period");
      rd(2'd2, s);
      chk(s == 8'hA0, "R6 rx-full after frame", s, 8'hA0);
      rd(2'd3, d);
      chk(d == rp, "R2 received byte", d, rp);
    end
    rd(2'd2, s);
    chk(s == 8'h20, "R6 rx-full cleared by sequence", s, 8'h20);

    // R4 gap-free burst, R7 overrun
    wr(2'd1, 8'h10);
    queue_byte(8'hA7, 8'h3C);
    queue_byte(8'h1E, 8'hC3);
    n_edge = 0;
    ss_n = 0;
    wait_txe();
    wr(2'd3, 8'hA7);
    wait_txe();
    wr(2'd3, 8'h1E);
    rd(2'd2, s);
    chk(s[5] == 0 && busy, "R5 tx-empty clear after second write", s, 0);
    wait_idle();
    ss_n = 1;
    edges_ok(16, 4, "R4 back-to-back burst without gap");
    rd(2'd2, s);
    chk(s == 8'hE0, "R7 overrun flagged", s, 8'hE0);
    rd(2'd3, d);
    chk(d == 8'hC3, "R7 newer byte kept", d, 8'hC3);
    rd(2'd2, s);
    chk(s == 8'h20, "R7 overrun cleared", s, 8'h20);

    // R5 unarmed write ignored, R6 unarmed read ignored
    queue_byte(8'h4D, 8'h81);
    n_edge = 0;
    ss_n = 0;
    wait_txe();
    wr(2'd3, 8'h4D);
    wait_idle();
    wr(2'd3, 8'hFF);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(n_edge == 8 && !busy, "R5 write without status read ignored", n_edge, 8);
    rd(2'd3, d);
    rd(2'd2, s);
    chk(s == 8'hA0, "R6 data read alone leaves rx-full", s, 8'hA0);
    rd(2'd3, d);
    chk(d == 8'h81, "R2 received byte after unarmed read", d, 8'h81);
    ss_n = 1;

    // R9 enable gating
    wr(2'd0, 8'h00);
    queue_byte(8'h6A, 8'h27);
    n_edge = 0;
    ss_n = 0;
    wait_txe();
    wr(2'd3, 8'h6A);
    rd(2'd2, s);
    chk(s == 8'h00, "R9 byte held in buffer while disabled", s, 8'h00);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(n_edge == 0 && !busy && !sclk, "R9 no clock while disabled", n_edge, 0);
    chk(!mosi, "R8 mosi low while idle", mosi, 0);
    wr(2'd0, 8'h01);
    wait_idle();
    ss_n = 1;
    edges_ok(8, 4, "R9 frame after enable");
    rd(2'd2, s);
    rd(2'd3, d);
    chk(d == 8'h27, "R2 received byte after enable", d, 8'h27);
    chk(exp_q.size() == 0, "R2 all queued bytes seen", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule